// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM interface. It takes the memory from power-on to a usable state. After reset it keeps the command pins idle for a power-up pause, whose length in cycles comes from a clock-frequency parameter and a pause-length parameter. It then precharges every bank and issues a programmable number of auto-refresh commands. It also writes the mode register and the extended mode register, placing each value on the address and bank lines. Every command is followed by the wait that command needs. When the last wait has run out, the block raises a done flag.

The core memory controller holds off its normal traffic until the done flag is high. The CAS latency, wrap type, burst length, option bits and extended register value are inputs that are sampled when the matching register write is issued. A parameter chooses whether the refresh commands come before or after the two register writes.

Top module: `sdram_boot_seq`

## Requirements
- R1: After reset is released, the command pins show exactly CLK_MHZ*PAUSE_US idle cycles. The first command is then precharge-all, with address bit 10 high and all other address and bank bits zero.
- R2: The command pins (cs_n, ras_n, cas_n, we_n) use these codes: idle 0111, precharge 0010, auto-refresh 0001, register write 0000. Every cycle between commands is idle.
- R3: The command that follows the precharge is issued exactly T_RP cycles after it.
- R4: Exactly N_REFRESH auto-refresh commands are issued. The command or completion that follows each refresh comes exactly T_RC cycles later.
- R5: The mode register write places burst length on A2..A0, wrap type on A3, CAS latency on A6..A4 and the option bits on A(ADDR_W-1)..A7. The bank lines carry MODE_BA (default 00).
- R6: The extended register write drives cfg_ext on the address lines and EXT_BA (default 10) on the bank lines. It directly follows the mode register write.
- R7: After each register write, the next command or completion comes exactly T_RSC cycles (at least 2) later. The cycle right after the write is idle.
- R8: With REFRESH_FIRST=1 the order is precharge, refreshes, mode write, extended write. With REFRESH_FIRST=0 the order is precharge, mode write, extended write, refreshes.
- R9: CKE is high at all times. DQM is high from reset through the precharge cycle and low from the next cycle on.
- R10: init_done rises exactly one wait period after the last command, using the wait that belongs to that command's kind. It then stays high, with idle commands, until reset.
- R11: Reset at any point returns idle commands, DQM high and init_done low, and restarts the whole sequence, including the full pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 3 | CAS latency code for A6..A4 |
| cfg_wrap | input | 1 | Wrap type bit for A3 |
| cfg_burst | input | 3 | Burst length code for A2..A0 |
| cfg_opt | input | ADDR_W-7 | Option bits for the upper address bits |
| cfg_ext | input | ADDR_W | Extended register value |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address lines |
| ba | output | BA_W | Bank lines |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask |
| init_done | output | 1 | Sequence complete |

## Verification
Two functions can land in the same cycle. One is the release of DQM after the precharge. The other is the next command, when T_RP is one cycle, which makes the register write fall in the first cycle with DQM low. One bench instance uses T_RP=1 to force this collision. The scoreboard then checks that the command arrives with no idle gap while DQM reads low in that same sample. A second collision is a reset arriving partway through the pause: the scoreboard expects the restarted run to count its pause again from zero.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;
   // pin code: {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_REGSET = 4'b0000,
      CMD_REFR   = 4'b0001,
      CMD_PREALL = 4'b0010,
      CMD_IDLE   = 4'b0111
   } sdram_cmd_e;

   typedef enum logic [1:0] {
      STEP_PRE,
      STEP_REFR,
      STEP_MODE,
      STEP_EXT
   } boot_step_e;
endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
   parameter int CNT_W = 16,
   parameter int START = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= CNT_W'(START);
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_boot_steps.sv
module sdram_boot_steps
   import sdram_boot_pkg::*;
#(
   parameter int N_REFRESH     = 2,
   parameter int REFRESH_FIRST = 1,
   parameter int IDX_W         = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       advance,
   output boot_step_e kind,
   output logic       last,
   output logic       past_first
);
   localparam int NSTEP = N_REFRESH + 3;

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx_q <= '0;
      else if (advance)  idx_q <= idx_q + 1'b1;
   end

   assign last       = (idx_q == IDX_W'(NSTEP - 1));
   assign past_first = (idx_q != '0);

   generate
      if (REFRESH_FIRST != 0) begin : g_refresh_first
         always_comb begin
            if (idx_q == '0)                          kind = STEP_PRE;
            else if (idx_q <= IDX_W'(N_REFRESH))      kind = STEP_REFR;
            else if (idx_q == IDX_W'(N_REFRESH + 1))  kind = STEP_MODE;
            else                                      kind = STEP_EXT;
         end
      end else begin : g_regs_first
         always_comb begin
            if (idx_q == '0)               kind = STEP_PRE;
            else if (idx_q == IDX_W'(1))   kind = STEP_MODE;
            else if (idx_q == IDX_W'(2))   kind = STEP_EXT;
            else                           kind = STEP_REFR;
         end
      end
   endgenerate
endmodule

// File: rtl/sdram_boot_cmd_out.sv
module sdram_boot_cmd_out
   import sdram_boot_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int BA_W    = 2,
   parameter int MODE_BA = 0,
   parameter int EXT_BA  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  boot_step_e        kind,
   input  logic              past_first,
   input  logic [ADDR_W-1:0] mode_word,
   input  logic [ADDR_W-1:0] ext_word,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              dqm
);
   localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << 10;

   sdram_cmd_e        cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BA_W-1:0]   ba_q;
   logic              dqm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= CMD_IDLE;
         addr_q <= '0;
         ba_q   <= '0;
         dqm_q  <= 1'b1;
      end else begin
         dqm_q  <= ~past_first;
         cmd_q  <= CMD_IDLE;
         addr_q <= '0;
         ba_q   <= '0;
         if (issue) begin
            unique case (kind)
               STEP_PRE: begin
                  cmd_q  <= CMD_PREALL;
                  addr_q <= PRE_ALL_ADDR;
               end
               STEP_REFR: cmd_q <= CMD_REFR;
               STEP_MODE: begin
                  cmd_q  <= CMD_REGSET;
                  addr_q <= mode_word;
                  ba_q   <= BA_W'(MODE_BA);
               end
               STEP_EXT: begin
                  cmd_q  <= CMD_REGSET;
                  addr_q <= ext_word;
                  ba_q   <= BA_W'(EXT_BA);
               end
               default: cmd_q <= CMD_IDLE;
            endcase
         end
      end
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
   assign addr = addr_q;
   assign ba   = ba_q;
   assign dqm  = dqm_q;
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
   import sdram_boot_pkg::*;
#(
   parameter int CLK_MHZ       = 200,
   parameter int PAUSE_US      = 200,
   parameter int T_RP          = 3,
   parameter int T_RC          = 10,
   parameter int T_RSC         = 2,
   parameter int N_REFRESH     = 2,
   parameter int REFRESH_FIRST = 1,
   parameter int ADDR_W        = 12,
   parameter int BA_W          = 2,
   parameter int MODE_BA       = 0,
   parameter int EXT_BA        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_cas_lat,
   input  logic              cfg_wrap,
   input  logic [2:0]        cfg_burst,
   input  logic [ADDR_W-8:0] cfg_opt,
   input  logic [ADDR_W-1:0] cfg_ext,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              cke,
   output logic              dqm,
   output logic              init_done
);
   localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
   localparam int MAX_A     = (PAUSE_CYC > T_RP) ? PAUSE_CYC : T_RP;
   localparam int MAX_B     = (T_RC > T_RSC) ? T_RC : T_RSC;
   localparam int MAX_WAIT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W     = $clog2(MAX_WAIT + 1);
   localparam int NSTEP     = N_REFRESH + 3;
   localparam int IDX_W     = $clog2(NSTEP);

   generate
      if (ADDR_W < 12)        begin : g_bad_addr  $error("ADDR_W must be at least 12"); end
      if (BA_W < 1)           begin : g_bad_ba    $error("BA_W must be at least 1"); end
      if (PAUSE_CYC < 1)      begin : g_bad_pause $error("pause must be at least one cycle"); end
      if (T_RP < 1)           begin : g_bad_rp    $error("T_RP must be at least 1"); end
      if (T_RC < 1)           begin : g_bad_rc    $error("T_RC must be at least 1"); end
      if (T_RSC < 2)          begin : g_bad_rsc   $error("T_RSC must be at least 2"); end
      if (N_REFRESH < 2)      begin : g_bad_nref  $error("N_REFRESH must be at least 2"); end
      if (MODE_BA >= (1 << BA_W) || EXT_BA >= (1 << BA_W))
                              begin : g_bad_sel   $error("bank select value does not fit BA_W"); end
   endgenerate

   boot_step_e        step_kind;
   logic              step_last;
   logic              step_past_first;
   logic              expired;
   logic              fire;
   logic              tail_q;
   logic              done_q;
   logic [CNT_W-1:0]  wait_val;
   logic [ADDR_W-1:0] mode_word;

   assign fire = expired & ~tail_q & ~done_q;

   always_comb begin
      unique case (step_kind)
         STEP_PRE:  wait_val = CNT_W'(T_RP - 1);
         STEP_REFR: wait_val = CNT_W'(T_RC - 1);
         default:   wait_val = CNT_W'(T_RSC - 1);
      endcase
   end

   assign mode_word = {cfg_opt, cfg_cas_lat, cfg_wrap, cfg_burst};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (fire && step_last)  tail_q <= 1'b1;
         if (tail_q && expired)  done_q <= 1'b1;
      end
   end

   sdram_boot_timer #(
      .CNT_W (CNT_W),
      .START (PAUSE_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fire),
      .load_val (wait_val),
      .expired  (expired)
   );

   sdram_boot_steps #(
      .N_REFRESH     (N_REFRESH),
      .REFRESH_FIRST (REFRESH_FIRST),
      .IDX_W         (IDX_W)
   ) u_steps (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance    (fire & ~step_last),
      .kind       (step_kind),
      .last       (step_last),
      .past_first (step_past_first)
   );

   sdram_boot_cmd_out #(
      .ADDR_W  (ADDR_W),
      .BA_W    (BA_W),
      .MODE_BA (MODE_BA),
      .EXT_BA  (EXT_BA)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (fire),
      .kind       (step_kind),
      .past_first (step_past_first),
      .mode_word  (mode_word),
      .ext_word   (cfg_ext),
      .cs_n       (cs_n),
      .ras_n      (ras_n),
      .cas_n      (cas_n),
      .we_n       (we_n),
      .addr       (addr),
      .ba         (ba),
      .dqm        (dqm)
   );

   assign cke       = 1'b1;
   assign init_done = done_q;
endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
   parameter int ADDR_W    = 12,
   parameter int BA_W      = 2,
   parameter int N_REFRESH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic [BA_W-1:0]   ba,
   input logic              dqm,
   input logic              init_done
);
   localparam logic [3:0] C_REG  = 4'b0000;
   localparam logic [3:0] C_REF  = 4'b0001;
   localparam logic [3:0] C_PRE  = 4'b0010;
   localparam logic [3:0] C_IDLE = 4'b0111;

   logic [3:0]  cmd;
   logic [15:0] ref_cnt;
   assign cmd = {cs_n, ras_n, cas_n, we_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ref_cnt <= '0;
      else if (cmd == C_REF)   ref_cnt <= ref_cnt + 1'b1;
   end

   // R1: precharge targets all banks
   p_pre_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_PRE) |-> (addr[10] && ba == '0));

   // R7: register write is never followed directly by a command
   p_rsc_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_REG) |=> (cmd == C_IDLE));

   // R9: DQM falls after precharge and stays low
   p_dqm_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_PRE) |=> !dqm);
   p_dqm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dqm |=> !dqm);
   p_pre_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dqm |-> (cmd == C_IDLE || cmd == C_PRE));

   // R10: completion is sticky and quiet
   p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
   p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cmd == C_IDLE));

   // R4: refresh count complete at completion
   p_ref_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (ref_cnt == 16'(N_REFRESH)));
endmodule

bind sdram_boot_seq sdram_boot_chk #(
   .ADDR_W    (ADDR_W),
   .BA_W      (BA_W),
   .N_REFRESH (N_REFRESH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .addr      (addr),
   .ba        (ba),
   .dqm       (dqm),
   .init_done (init_done)
);

// File: tb/sdram_boot_seq_tb.sv
module sdram_boot_seq_tb_top;
   localparam logic [3:0] C_REG  = 4'b0000;
   localparam logic [3:0] C_REF  = 4'b0001;
   localparam logic [3:0] C_PRE  = 4'b0010;
   localparam logic [3:0] C_IDLE = 4'b0111;
   localparam logic [3:0] K_DONE = 4'b1111;
   localparam int PAUSE = 200;   // 200 MHz * 1 us

   // per-instance settings: index 0 = dut_i, index 1 = dut_b
   localparam int P_RP [2] = '{3, 1};
   localparam int P_RC [2] = '{5, 4};
   localparam int P_RSC[2] = '{2, 3};
   localparam int P_NR [2] = '{3, 2};
   localparam int P_RF [2] = '{1, 0};

   typedef struct {
      logic [3:0]  kind;
      logic [11:0] addr;
      logic [1:0]  ba;
      int          gap;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_cas_lat = 3'd3;
   logic        cfg_wrap = 1'b0;
   logic [2:0]  cfg_burst = 3'd3;
   logic [4:0]  cfg_opt = 5'd0;
   logic [11:0] cfg_ext = 12'h020;

   logic        cs_n [2], ras_n [2], cas_n [2], we_n [2];
   logic [11:0] addr [2];
   logic [1:0]  ba [2];
   logic        cke [2], dqm [2], done [2];

   exp_t q[2][$];
   int   nops[2];
   bit   pre_seen[2];
   bit   done_seen[2];
   int   total = 0;
   int   bad = 0;
   int   cycles = 0;
   bit   finished = 1'b0;

   always #2.5 clk = ~clk;

   sdram_boot_seq #(.CLK_MHZ(200), .PAUSE_US(1), .T_RP(P_RP[0]), .T_RC(P_RC[0]),
      .T_RSC(P_RSC[0]), .N_REFRESH(P_NR[0]), .REFRESH_FIRST(P_RF[0])) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_wrap(cfg_wrap),
      .cfg_burst(cfg_burst), .cfg_opt(cfg_opt), .cfg_ext(cfg_ext),
      .cs_n(cs_n[0]), .ras_n(ras_n[0]), .cas_n(cas_n[0]), .we_n(we_n[0]),
      .addr(addr[0]), .ba(ba[0]), .cke(cke[0]), .dqm(dqm[0]), .init_done(done[0]));

   sdram_boot_seq #(.CLK_MHZ(200), .PAUSE_US(1), .T_RP(P_RP[1]), .T_RC(P_RC[1]),
      .T_RSC(P_RSC[1]), .N_REFRESH(P_NR[1]), .REFRESH_FIRST(P_RF[1])) dut_b (
      .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_wrap(cfg_wrap),
      .cfg_burst(cfg_burst), .cfg_opt(cfg_opt), .cfg_ext(cfg_ext),
      .cs_n(cs_n[1]), .ras_n(ras_n[1]), .cas_n(cas_n[1]), .we_n(we_n[1]),
      .addr(addr[1]), .ba(ba[1]), .cke(cke[1]), .dqm(dqm[1]), .init_done(done[1]));

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push(input int d, input logic [3:0] k, input logic [11:0] a,
                       input logic [1:0] b, input int g, input string tag);
      exp_t e;
      e.kind = k; e.addr = a; e.ba = b; e.gap = g; e.tag = tag;
      q[d].push_back(e);
   endtask

   // driver: expected command stream from the requirements
   task automatic load_plan(input int d);
      logic [11:0] mw;
      int prev;
      mw = {cfg_opt, cfg_cas_lat, cfg_wrap, cfg_burst};
      q[d].delete();
      push(d, C_PRE, 12'h400, 2'd0, PAUSE, "R1");
      if (P_RF[d] != 0) begin
         prev = P_RP[d];
         for (int i = 0; i < P_NR[d]; i++) begin
            push(d, C_REF, 12'h000, 2'd0, prev - 1, (i == 0) ? "R3" : "R4");
            prev = P_RC[d];
         end
         push(d, C_REG, mw, 2'd0, prev - 1, "R5");
         push(d, C_REG, cfg_ext, 2'd2, P_RSC[d] - 1, "R6");
         push(d, K_DONE, 12'h000, 2'd0, P_RSC[d] - 1, "R7");
      end else begin
         push(d, C_REG, mw, 2'd0, P_RP[d] - 1, "R3");
         push(d, C_REG, cfg_ext, 2'd2, P_RSC[d] - 1, "R6");
         prev = P_RSC[d];
         for (int i = 0; i < P_NR[d]; i++) begin
            push(d, C_REF, 12'h000, 2'd0, prev - 1, (i == 0) ? "R8" : "R4");
            prev = P_RC[d];
         end
         push(d, K_DONE, 12'h000, 2'd0, prev - 1, "R10");
      end
   endtask

   // monitor: compares outputs against the queue at each falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < 2; d++) begin
            nops[d] = 0; pre_seen[d] = 1'b0; done_seen[d] = 1'b0;
         end
      end else if (!finished) begin
         for (int d = 0; d < 2; d++) begin
            logic [3:0] c;
            exp_t e;
            c = {cs_n[d], ras_n[d], cas_n[d], we_n[d]};
            chk(cke[d] == 1'b1, "R9", "cke", int'(cke[d]), 1);
            chk(dqm[d] == !pre_seen[d], "R9", "dqm", int'(dqm[d]), int'(!pre_seen[d]));
            if (done_seen[d]) begin
               chk(done[d] && c == C_IDLE, "R10", "quiet after done",
                   int'({done[d], c}), int'({1'b1, C_IDLE}));
            end else if (c != C_IDLE || done[d]) begin
               if (q[d].size() == 0) begin
                  chk(1'b0, "R2", "unexpected event", int'(c), int'(C_IDLE));
               end else begin
                  e = q[d].pop_front();
                  if (e.kind == K_DONE) begin
                     chk(done[d] && c == C_IDLE, e.tag, "done event",
                         int'({done[d], c}), int'({1'b1, C_IDLE}));
                     done_seen[d] = 1'b1;
                     chk(q[d].size() == 0, "R10", "items left", q[d].size(), 0);
                  end else begin
                     chk(c == e.kind, "R2", "command code", int'(c), int'(e.kind));
                     chk(!done[d], "R10", "done early", int'(done[d]), 0);
                     chk(addr[d] == e.addr, e.tag, "address", int'(addr[d]), int'(e.addr));
                     chk(ba[d] == e.ba, e.tag, "bank", int'(ba[d]), int'(e.ba));
                     if (c == C_PRE) pre_seen[d] = 1'b1;
                  end
                  chk(nops[d] == e.gap, e.tag, "idle gap", nops[d], e.gap);
               end
               nops[d] = 0;
            end else begin
               nops[d]++;
            end
         end
      end
   end

   task automatic check_reset_state();
      for (int d = 0; d < 2; d++) begin
         chk({cs_n[d], ras_n[d], cas_n[d], we_n[d]} == C_IDLE, "R11", "reset cmd",
             int'({cs_n[d], ras_n[d], cas_n[d], we_n[d]}), int'(C_IDLE));
         chk(dqm[d] && !done[d], "R11", "reset dqm/done",
             int'({dqm[d], done[d]}), 2);
      end
   endtask

   task automatic drive_step();
      @(negedge clk); #1;
   endtask

   task automatic start_run();
      load_plan(0);
      load_plan(1);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      while (!(done_seen[0] && done_seen[1])) drive_step();
      repeat (10) drive_step();
      for (int d = 0; d < 2; d++)
         chk(q[d].size() == 0, "R10", "unconsumed items", q[d].size(), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !finished) begin
         finished = 1'b1;
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) drive_step();
      check_reset_state();
      start_run();                 // R8: both orders run side by side
      finish_run();

      // reset after completion, new configuration
      rst_n = 1'b0;
      cfg_cas_lat = 3'd2; cfg_wrap = 1'b1; cfg_burst = 3'd7;
      cfg_opt = 5'h15; cfg_ext = 12'h5A3;
      repeat (3) drive_step();
      check_reset_state();
      start_run();
      repeat (100) drive_step();   // R11: abort inside the pause
      rst_n = 1'b0;
      repeat (2) drive_step();
      check_reset_state();
      start_run();
      finish_run();

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule